// File: doc/BRIEF.md
# Address Translator with Recency-Ranked Buffer

This block maps a 16-bit virtual address onto a physical address with 4 KB pages. The top 4 bits are the virtual page number and the low 12 bits are the page offset. A four-entry, fully associative translation buffer is searched first, and all of its entries are compared at once. If the buffer does not hold the page, the block reads a 16-entry page table held in local registers. That table is indexed directly by the page number from a base of zero.

A successful table read is installed in the buffer and returned. An invalid table entry is reported as a page fault, and in that case the buffer is left as it was. Each buffer entry carries a recency rank from 1 (most recent) to 4 (least recent). The rank decides which entry is overwritten when the buffer is full. Software or a loader fills the page table through a single-entry write port.

Top module: `xlat_unit`

## Requirements
- R1: On every successful translation, bits 11:0 of `rspPaddr` equal bits 11:0 of the requested virtual address.
- R2: A request whose page number matches a valid buffer entry is answered in the next cycle. The answer has `rspValid`=1, `rspHit`=1, `rspFault`=0 and `rspPaddr` = {stored physical page, offset}, and `busy` stays 0.
- R3: A request that misses in the buffer raises `busy` in the following cycle. The answer (`rspValid`=1, `rspHit`=0) arrives one cycle later, and `busy` is back at 0 in that cycle. Requests presented while `busy` is 1 are dropped and never produce an answer.
- R4: On a miss where the page-table entry at index = page number is valid, the answer carries `rspFault`=0 and `rspPaddr` = {table physical page, offset}. The translation is also written into the buffer, so a later request to the same page hits.
- R5: On a miss where the page-table entry is invalid, the answer carries `rspFault`=1 and `rspPaddr`=0. Buffer contents and ranks stay unchanged.
- R6: On a hit, the hit entry takes rank 1. Entries whose rank was below the hit entry's old rank move down by one, and all other ranks keep their value.
- R7: A refill overwrites the lowest-index invalid entry, or the rank-4 entry when all entries are valid. The new entry takes rank 1, and the other ranks change as in R6.
- R8: While reset is asserted, all buffer entries and all page-table entries are marked invalid, and entry i receives rank i+1. After reset, `busy` and `rspValid` are 0 until a request arrives.
- R9: When `ptWrEn`=1 at a clock edge, the page-table entry at `ptWrIdx` takes `ptWrValid` and `ptWrPpn`. Table reads starting after that edge see the new value. A write does not change translations already held in the buffer.
- R10: The four ranks always form a permutation of 1 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request strobe |
| reqVaddr | input | 16 | Virtual address of the request |
| busy | output | 1 | High during a page-table read; requests are dropped |
| rspValid | output | 1 | Response strobe, one cycle wide |
| rspHit | output | 1 | Response came from the buffer |
| rspFault | output | 1 | Page-table entry was invalid |
| rspPaddr | output | 16 | Physical address, zero on a fault |
| ptWrEn | input | 1 | Page-table write strobe |
| ptWrIdx | input | 4 | Page-table entry to write |
| ptWrValid | input | 1 | Valid bit to store |
| ptWrPpn | input | 4 | Physical page number to store |

## Verification
The assertions assume the environment only raises `reqValid` in order to issue requests. They do not require requests to stop while `busy` is high, because such requests are dropped by design. They also assume that page-table writes never coincide with the table read of a miss in progress. The stimulus issues each request for one cycle, and during every miss it deliberately presents a dropped request. Page-table writes are issued only between complete transactions, so the second assumption holds.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } xlatState_t;

  // Strobes from control to datapath for the current cycle
  typedef struct packed {
    logic hitCommit;   // request hits: respond and touch ranks
    logic startWalk;   // request misses: capture it for the table read
    logic walk;        // table read happens at this edge
  } xlatStrobe_t;

endpackage

// File: rtl/xlat_ptab.sv
module xlat_ptab #(
  parameter int VPN_W = 4,
  parameter int PPN_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [VPN_W-1:0] wrIdx,
  input  logic             wrValid,
  input  logic [PPN_W-1:0] wrPpn,
  input  logic [VPN_W-1:0] rdIdx,
  output logic             rdValid,
  output logic [PPN_W-1:0] rdPpn
);
  localparam int DEPTH = 1 << VPN_W;

  logic             validQ [DEPTH];
  logic [PPN_W-1:0] ppnQ   [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rstN) begin
        validQ[i] <= 1'b0;
        ppnQ[i]   <= '0;
      end else if (wrEn && (wrIdx == VPN_W'(i))) begin
        validQ[i] <= wrValid;
        ppnQ[i]   <= wrPpn;
      end
    end
  end

  assign rdValid = validQ[rdIdx];
  assign rdPpn   = ppnQ[rdIdx];

endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        anyHit,
  output xlatStrobe_t strb,
  output logic        busy
);
  xlatState_t stateQ, stateD;
  logic       accept;

  assign accept = reqValid && (stateQ == ST_IDLE);

  always_comb begin
    strb.hitCommit = accept && anyHit;
    strb.startWalk = accept && !anyHit;
    strb.walk      = (stateQ == ST_WALK);
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: if (accept && !anyHit) stateD = ST_WALK;
      ST_WALK: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign busy = (stateQ == ST_WALK);

endmodule

// File: rtl/xlat_dp.sv
module xlat_dp
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int VPN_W   = 4,
  parameter int PPN_W   = 4,
  parameter int OFF_W   = 12,
  parameter int RANK_W  = $clog2(ENTRIES + 1),
  parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  xlatStrobe_t               strb,
  input  logic [VPN_W-1:0]          reqVpn,
  input  logic [OFF_W-1:0]          reqOff,
  output logic                      anyHit,
  output logic [VPN_W-1:0]          ptIdx,
  input  logic                      ptValid,
  input  logic [PPN_W-1:0]          ptPpn,
  output logic                      rspValid,
  output logic                      rspHit,
  output logic                      rspFault,
  output logic [PPN_W+OFF_W-1:0]    rspPaddr,
  output logic [ENTRIES-1:0]        validVec,
  output logic [ENTRIES*RANK_W-1:0] rankVec
);
  localparam int PA_W = PPN_W + OFF_W;

  logic              validQ [ENTRIES];
  logic [RANK_W-1:0] rankQ  [ENTRIES];
  logic [VPN_W-1:0]  tagQ   [ENTRIES];
  logic [PPN_W-1:0]  ppnQ   [ENTRIES];

  logic [VPN_W-1:0]  pendVpnQ;
  logic [OFF_W-1:0]  pendOffQ;

  logic [ENTRIES-1:0] matchVec;
  logic [IDX_W-1:0]   hitIdx;
  logic [IDX_W-1:0]   victimIdx;
  logic [IDX_W-1:0]   touchIdx;
  logic               touchEn;
  logic               refillEn;
  logic [RANK_W-1:0]  oldRank;

  // Parallel tag compare, lowest matching index wins
  always_comb begin
    logic found;
    found  = 1'b0;
    hitIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      matchVec[i] = validQ[i] && (tagQ[i] == reqVpn);
      if (matchVec[i] && !found) begin
        found  = 1'b1;
        hitIdx = IDX_W'(i);
      end
    end
    anyHit = found;
  end

  // Victim: first empty slot, else the least recently used one
  always_comb begin
    logic foundEmpty;
    foundEmpty = 1'b0;
    victimIdx  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!validQ[i] && !foundEmpty) begin
        foundEmpty = 1'b1;
        victimIdx  = IDX_W'(i);
      end
    end
    if (!foundEmpty) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (rankQ[i] == RANK_W'(ENTRIES)) victimIdx = IDX_W'(i);
      end
    end
  end

  assign ptIdx    = pendVpnQ;
  assign refillEn = strb.walk && ptValid;
  assign touchEn  = strb.hitCommit || refillEn;
  assign touchIdx = strb.hitCommit ? hitIdx : victimIdx;
  assign oldRank  = rankQ[touchIdx];

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (!rstN) begin
        validQ[i] <= 1'b0;
        rankQ[i]  <= RANK_W'(i + 1);
        tagQ[i]   <= '0;
        ppnQ[i]   <= '0;
      end else begin
        if (touchEn) begin
          if (touchIdx == IDX_W'(i))    rankQ[i] <= RANK_W'(1);
          else if (rankQ[i] < oldRank)  rankQ[i] <= rankQ[i] + RANK_W'(1);
        end
        if (refillEn && (victimIdx == IDX_W'(i))) begin
          validQ[i] <= 1'b1;
          tagQ[i]   <= pendVpnQ;
          ppnQ[i]   <= ptPpn;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendVpnQ <= '0;
      pendOffQ <= '0;
    end else if (strb.startWalk) begin
      pendVpnQ <= reqVpn;
      pendOffQ <= reqOff;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspFault <= 1'b0;
      rspPaddr <= '0;
    end else begin
      rspValid <= strb.hitCommit || strb.walk;
      rspHit   <= strb.hitCommit;
      rspFault <= strb.walk && !ptValid;
      if (strb.hitCommit)  rspPaddr <= {ppnQ[hitIdx], reqOff};
      else if (refillEn)   rspPaddr <= {ptPpn, pendOffQ};
      else                 rspPaddr <= PA_W'(0);
    end
  end

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
      assign validVec[g]                     = validQ[g];
      assign rankVec[g*RANK_W +: RANK_W]     = rankQ[g];
    end
  endgenerate

endmodule

// File: rtl/xlat_unit.sv
module xlat_unit
  import xlat_pkg::*;
#(
  parameter int VA_W    = 16,
  parameter int OFF_W   = 12,
  parameter int PPN_W   = 4,
  parameter int ENTRIES = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic [VA_W-1:0]        reqVaddr,
  output logic                   busy,
  output logic                   rspValid,
  output logic                   rspHit,
  output logic                   rspFault,
  output logic [PPN_W+OFF_W-1:0] rspPaddr,
  input  logic                   ptWrEn,
  input  logic [VA_W-OFF_W-1:0]  ptWrIdx,
  input  logic                   ptWrValid,
  input  logic [PPN_W-1:0]       ptWrPpn
);
  localparam int VPN_W  = VA_W - OFF_W;
  localparam int RANK_W = $clog2(ENTRIES + 1);

  xlatStrobe_t               strb;
  logic                      anyHit;
  logic [VPN_W-1:0]          ptIdx;
  logic                      ptValid;
  logic [PPN_W-1:0]          ptPpn;
  logic [ENTRIES-1:0]        validVec;
  logic [ENTRIES*RANK_W-1:0] rankVec;

  xlat_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .anyHit  (anyHit),
    .strb    (strb),
    .busy    (busy)
  );

  xlat_dp #(
    .ENTRIES(ENTRIES),
    .VPN_W  (VPN_W),
    .PPN_W  (PPN_W),
    .OFF_W  (OFF_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .reqVpn  (reqVaddr[VA_W-1:OFF_W]),
    .reqOff  (reqVaddr[OFF_W-1:0]),
    .anyHit  (anyHit),
    .ptIdx   (ptIdx),
    .ptValid (ptValid),
    .ptPpn   (ptPpn),
    .rspValid(rspValid),
    .rspHit  (rspHit),
    .rspFault(rspFault),
    .rspPaddr(rspPaddr),
    .validVec(validVec),
    .rankVec (rankVec)
  );

  xlat_ptab #(
    .VPN_W(VPN_W),
    .PPN_W(PPN_W)
  ) u_ptab (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (ptWrEn),
    .wrIdx  (ptWrIdx),
    .wrValid(ptWrValid),
    .wrPpn  (ptWrPpn),
    .rdIdx  (ptIdx),
    .rdValid(ptValid),
    .rdPpn  (ptPpn)
  );

endmodule

// File: rtl/xlat_chk.sv
module xlat_chk #(
  parameter int ENTRIES = 4,
  parameter int RANK_W  = 3,
  parameter int PA_W    = 16
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      reqValid,
  input logic                      busy,
  input logic                      rspValid,
  input logic                      rspHit,
  input logic                      rspFault,
  input logic [PA_W-1:0]           rspPaddr,
  input logic [ENTRIES-1:0]        validVec,
  input logic [ENTRIES*RANK_W-1:0] rankVec
);
  logic [ENTRIES-1:0] seenRank;

  always_comb begin
    seenRank = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      for (int k = 1; k <= ENTRIES; k++) begin
        if (rankVec[i*RANK_W +: RANK_W] == RANK_W'(k)) seenRank[k-1] = 1'b1;
      end
    end
  end

  AST_RANK_PERM: assert property (@(posedge clk) disable iff (!rstN)
    &seenRank);                                                           // R10
  AST_HIT_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspHit |-> $past(reqValid) && !$past(busy) && !rspFault); // R2
  AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);                                                      // R3
  AST_WALK_ANSWER: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> rspValid && !rspHit);                                 // R3
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(busy) || $past(reqValid));                         // R3
  AST_FAULT_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspFault |-> $stable(rankVec) && $stable(validVec) && rspPaddr == '0); // R5

endmodule

bind xlat_unit xlat_chk #(
  .ENTRIES(ENTRIES),
  .RANK_W (RANK_W),
  .PA_W   (PPN_W + OFF_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .busy    (busy),
  .rspValid(rspValid),
  .rspHit  (rspHit),
  .rspFault(rspFault),
  .rspPaddr(rspPaddr),
  .validVec(validVec),
  .rankVec (rankVec)
);

// File: tb/sim_xlat_unit.sv
`timescale 1ns/1ps
module sim_xlat_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [15:0] reqVaddr = '0;
  logic        busy, rspValid, rspHit, rspFault;
  logic [15:0] rspPaddr;
  logic        ptWrEn = 1'b0;
  logic [3:0]  ptWrIdx = '0;
  logic        ptWrValid = 1'b0;
  logic [3:0]  ptWrPpn = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference model
  bit       mValid [4];
  int       mRank  [4];
  int       mTag   [4];
  int       mPpn   [4];
  bit       pValid [16];
  int       pPpn   [16];

  always #2 clk = ~clk;

  xlat_unit u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVaddr(reqVaddr),
    .busy(busy), .rspValid(rspValid), .rspHit(rspHit), .rspFault(rspFault),
    .rspPaddr(rspPaddr), .ptWrEn(ptWrEn), .ptWrIdx(ptWrIdx),
    .ptWrValid(ptWrValid), .ptWrPpn(ptWrPpn)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic touch(input int idx);
    int old;
    old = mRank[idx];
    for (int j = 0; j < 4; j++) if (mRank[j] < old) mRank[j]++;
    mRank[idx] = 1;
  endtask

  task automatic doReset();
    rstN = 1'b0; reqValid = 1'b0; ptWrEn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 4; i++) begin
      mValid[i] = 0; mRank[i] = i + 1; mTag[i] = 0; mPpn[i] = 0;
    end
    for (int i = 0; i < 16; i++) begin pValid[i] = 0; pPpn[i] = 0; end
    @(negedge clk);
    chk(!busy && !rspValid, "R8 idle after reset", {busy, rspValid}, 0);
  endtask

  task automatic ptWrite(input int idx, input bit v, input int ppn);
    ptWrEn = 1'b1; ptWrIdx = idx[3:0]; ptWrValid = v; ptWrPpn = ppn[3:0];
    @(negedge clk);
    ptWrEn = 1'b0;
    pValid[idx] = v; pPpn[idx] = ppn;
  endtask

  task automatic doXlat(input logic [15:0] va, input string ctx);
    int vpn, off, hitAt, vic;
    vpn = int'(va[15:12]); off = int'(va[11:0]);
    hitAt = -1;
    for (int i = 0; i < 4; i++) if (mValid[i] && mTag[i] == vpn && hitAt < 0) hitAt = i;
    reqValid = 1'b1; reqVaddr = va;
    @(negedge clk);
    if (hitAt >= 0) begin
      reqValid = 1'b0;
      chk(rspValid && rspHit && !rspFault && !busy, {ctx, " R2 hit flags"},
          {rspValid, rspHit, rspFault, busy}, 4'b1100);
      chk(rspPaddr == 16'((mPpn[hitAt] << 12) | off), {ctx, " R2 hit address"},
          rspPaddr, (mPpn[hitAt] << 12) | off);
      chk(rspPaddr[11:0] == va[11:0], {ctx, " R1 offset"}, rspPaddr[11:0], off);
      touch(hitAt);
    end else begin
      chk(busy && !rspValid, {ctx, " R3 busy on miss"}, {busy, rspValid}, 2'b10);
      reqVaddr = ~va;  // dropped request while busy
      @(negedge clk);
      reqValid = 1'b0;
      chk(rspValid && !rspHit && !busy, {ctx, " R3 walk answer"},
          {rspValid, rspHit, busy}, 3'b100);
      if (pValid[vpn]) begin
        chk(!rspFault && rspPaddr == 16'((pPpn[vpn] << 12) | off), {ctx, " R4 table address"},
            {rspFault, rspPaddr}, (pPpn[vpn] << 12) | off);
        chk(rspPaddr[11:0] == va[11:0], {ctx, " R1 offset"}, rspPaddr[11:0], off);
        vic = -1;
        for (int i = 0; i < 4; i++) if (!mValid[i] && vic < 0) vic = i;
        if (vic < 0) for (int i = 0; i < 4; i++) if (mRank[i] == 4) vic = i;
        mValid[vic] = 1; mTag[vic] = vpn; mPpn[vic] = pPpn[vpn];
        touch(vic);
      end else begin
        chk(rspFault && rspPaddr == 16'h0, {ctx, " R5 fault"}, {rspFault, rspPaddr}, 17'h10000);
      end
      @(negedge clk);
      chk(!rspValid && !busy, {ctx, " R3 dropped request"}, {rspValid, busy}, 0);
    end
  endtask

  initial begin
    doReset();
    doXlat(16'h3abc, "R8 empty table");
    doXlat(16'h3abc, "R8 still empty");
    for (int i = 0; i < 16; i++) ptWrite(i, (i % 5) != 3, (i * 7 + 3) & 15);
    doXlat(16'h0123, "R9 fill");
    doXlat(16'h1456, "R7 fill empty");
    doXlat(16'h2789, "R7 fill empty");
    doXlat(16'h4abc, "R7 fill empty");
    doXlat(16'h0fff, "R6 hit oldest");
    doXlat(16'h5000, "R7 evict rank 4");
    doXlat(16'h1001, "R7 evicted page misses");
    doXlat(16'h3777, "R5 fault");
    doXlat(16'h4777, "R5 buffer intact");
    doXlat(16'h0888, "R5 buffer intact");
    doXlat(16'h2999, "R6 order after fault");
    for (int k = 0; k < 400; k++) begin
      int vpn;
      vpn = ((k * k * 7 + k) >> 1) % 6 + ((k / 50) % 3) * 5;
      vpn = vpn % 16;
      if (k == 200) begin
        for (int i = 0; i < 16; i++) ptWrite(i, (i % 4) != 0, 15 - i);
      end
      doXlat(16'((vpn << 12) | ((k * 37 + 5) & 12'hfff)), k < 200 ? "R6 sweep" : "R9 sweep");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule